// File: doc/BRIEF.md
# I2C Slave Address Matcher and Acknowledge Decider

This block sits beside the receive shift register of a two-wire serial bus node. When a whole byte has been shifted in, the bus logic gives it a one-cycle strobe and tells it whether the byte is the first one after a START, which is the address byte, or a data byte. For an address byte the block compares the seven address bits with a programmable node address. When general-call support is on, it also accepts the all-zero write address. It then raises a one-cycle match pulse, together with a general-call flag and the direction bit. For every byte it also decides whether the node pulls the acknowledge slot low. It holds that decision until the bus logic reports that the acknowledge clock has finished.

The bus logic should raise the byte strobe on the falling SCL edge that ends the eighth bit. The acknowledge level is then already registered before the ninth rising edge. The block uses only bus-side inputs and its own clock. It has no dependency on host activity, so its match pulse can serve as a wake source while the host is in a low-power state. Clearing the acknowledge enable takes the node off the bus logically. It stops answering to its address and stops acknowledging data, while the surrounding logic keeps following the traffic.

Top module: `i2c_addr_matcher`

## Requirements
- R1: While reset is asserted and on the first cycle after it, match_pulse, match_gc, match_rw and ack_drive are all 0.
- R2: An address byte (byte_is_addr=1) whose upper seven bits, rx_byte[7:1], equal a nonzero own_addr, strobed while ack_enable=1, makes match_pulse high on the cycle after the strobe for exactly one cycle.
- R3: The byte 8'h00 counts as a general-call match only while gc_enable=1; then match_pulse and match_gc are both 1. The byte 8'h01 is never a general-call match.
- R4: An own_addr of 7'h00 is reserved and never produces an own-address match.
- R5: On a match, match_rw takes rx_byte[0] of the address byte. match_rw and match_gc keep their values until the next match.
- R6: For an address byte, ack_drive goes high on the cycle after the strobe exactly when that byte matched. It then stays high until an ack_done pulse and goes low on the cycle after it.
- R7: While ack_enable=0, no address byte gives a match pulse or an acknowledge. Setting ack_enable back to 1 resumes matching at the next address byte.
- R8: For a data byte (byte_is_addr=0), ack_drive is set when ack_enable=1 and xfer_mode is master-receive (2'd2) or slave-receive (2'd3). It is cleared in idle (2'd0) and master-transmit (2'd1). A data byte never raises match_pulse.
- R9: If ack_done and the byte strobe arrive in the same cycle, the new byte's decision sets ack_drive.
- R10: An address byte that does not match raises no pulse, clears ack_drive and leaves match_rw and match_gc unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| byte_valid | input | 1 | One-cycle strobe: a full byte is in rx_byte |
| byte_is_addr | input | 1 | Strobed byte is the first after START |
| rx_byte | input | 8 | Received byte, bit 0 is the direction bit for addresses |
| own_addr | input | 7 | Programmable node address |
| gc_enable | input | 1 | Accept the general-call address |
| ack_enable | input | 1 | Allow any acknowledge and address recognition |
| xfer_mode | input | 2 | 0 idle, 1 master-transmit, 2 master-receive, 3 slave-receive |
| ack_done | input | 1 | Acknowledge clock finished, release ack_drive |
| match_pulse | output | 1 | One-cycle address match indication |
| match_gc | output | 1 | Last match was a general call |
| match_rw | output | 1 | Direction bit of the last matched address |
| ack_drive | output | 1 | Pull the acknowledge slot low |

## Verification
A wrong decision shows on the ports exactly one cycle after the byte strobe. Either match_pulse or ack_drive takes the wrong level there, and this is the same edge on which the node would drive the acknowledge slot. A corrupted hold state is caught the cycle it diverges. A captured direction or general-call bit that changes without a match, or an acknowledge that drops before ack_done or survives past it, shows up on the next cycle. Because the reference is compared every clock, the bench sees a stray extra pulse or a pulse held for two cycles at once.

// File: rtl/i2c_addr_matcher_pkg.sv
package i2c_addr_matcher_pkg;

   typedef enum logic [1:0] {
      XM_IDLE = 2'd0,
      XM_MTX  = 2'd1,
      XM_MRX  = 2'd2,
      XM_SRX  = 2'd3
   } xfer_mode_e;

   typedef struct packed {
      logic hit;
      logic gc;
      logic rw;
      logic ack;
   } byte_decision_t;

endpackage

// File: rtl/iam_addr_cmp.sv
module iam_addr_cmp #(
   parameter int ADDR_W     = 7,
   parameter bit GC_SUPPORT = 1'b1,
   localparam int BYTE_W    = ADDR_W + 1
) (
   input  logic [BYTE_W-1:0] rx_byte,
   input  logic [ADDR_W-1:0] own_addr,
   input  logic              gc_enable,
   output logic              own_hit,
   output logic              gc_hit
);

   logic [ADDR_W-1:0] bit_eq;

   // Per-bit comparator, one XNOR per address bit
   for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
      assign bit_eq[i] = rx_byte[i+1] ~^ own_addr[i];
   end

   // The all-zero address is reserved for the general call
   assign own_hit = (&bit_eq) & (|own_addr);

   if (GC_SUPPORT) begin : g_gc
      assign gc_hit = gc_enable & ~(|rx_byte);
   end else begin : g_no_gc
      assign gc_hit = gc_enable & 1'b0;
   end

endmodule

// File: rtl/iam_ack_policy.sv
module iam_ack_policy
   import i2c_addr_matcher_pkg::*;
(
   input  logic           own_hit,
   input  logic           gc_hit,
   input  logic           byte_is_addr,
   input  logic           ack_enable,
   input  logic           dir_bit,
   input  logic [1:0]     xfer_mode,
   output byte_decision_t dec
);

   xfer_mode_e mode;
   logic       rx_mode;

   assign mode    = xfer_mode_e'(xfer_mode);
   assign rx_mode = (mode == XM_MRX) || (mode == XM_SRX);

   always_comb begin
      dec     = '0;
      dec.gc  = gc_hit;
      dec.rw  = dir_bit;
      if (byte_is_addr) begin
         dec.hit = ack_enable & (own_hit | gc_hit);
         dec.ack = dec.hit;
      end else begin
         dec.hit = 1'b0;
         dec.ack = ack_enable & rx_mode;
      end
   end

endmodule

// File: rtl/iam_out_reg.sv
module iam_out_reg
   import i2c_addr_matcher_pkg::*;
(
   input  logic           clk,
   input  logic           rst_n,
   input  logic           byte_valid,
   input  logic           ack_done,
   input  byte_decision_t dec,
   output logic           match_pulse,
   output logic           match_gc,
   output logic           match_rw,
   output logic           ack_drive
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         match_pulse <= 1'b0;
         match_gc    <= 1'b0;
         match_rw    <= 1'b0;
         ack_drive   <= 1'b0;
      end else begin
         match_pulse <= byte_valid & dec.hit;
         if (byte_valid && dec.hit) begin
            match_gc <= dec.gc;
            match_rw <= dec.rw;
         end
         if (byte_valid)
            ack_drive <= dec.ack;
         else if (ack_done)
            ack_drive <= 1'b0;
      end
   end

   // R2
   pulse_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      match_pulse |-> $past(byte_valid));

   // R6
   ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack_drive && !byte_valid && !ack_done |=> ack_drive);

   // R6
   ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack_done && !byte_valid |=> !ack_drive);

   // R5
   rw_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !match_pulse |-> $stable(match_rw) && $stable(match_gc));

endmodule

// File: rtl/i2c_addr_matcher.sv
module i2c_addr_matcher
   import i2c_addr_matcher_pkg::*;
#(
   parameter int ADDR_W     = 7,
   parameter bit GC_SUPPORT = 1'b1,
   localparam int BYTE_W    = ADDR_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              byte_valid,
   input  logic              byte_is_addr,
   input  logic [BYTE_W-1:0] rx_byte,
   input  logic [ADDR_W-1:0] own_addr,
   input  logic              gc_enable,
   input  logic              ack_enable,
   input  logic [1:0]        xfer_mode,
   input  logic              ack_done,
   output logic              match_pulse,
   output logic              match_gc,
   output logic              match_rw,
   output logic              ack_drive
);

   if (ADDR_W < 1 || ADDR_W > 10) begin : g_bad_width
      $error("i2c_addr_matcher: ADDR_W out of range");
   end

   logic           own_hit;
   logic           gc_hit;
   byte_decision_t dec;

   iam_addr_cmp #(
      .ADDR_W     (ADDR_W),
      .GC_SUPPORT (GC_SUPPORT)
   ) u_cmp (
      .rx_byte   (rx_byte),
      .own_addr  (own_addr),
      .gc_enable (gc_enable),
      .own_hit   (own_hit),
      .gc_hit    (gc_hit)
   );

   iam_ack_policy u_policy (
      .own_hit      (own_hit),
      .gc_hit       (gc_hit),
      .byte_is_addr (byte_is_addr),
      .ack_enable   (ack_enable),
      .dir_bit      (rx_byte[0]),
      .xfer_mode    (xfer_mode),
      .dec          (dec)
   );

   iam_out_reg u_out (
      .clk         (clk),
      .rst_n       (rst_n),
      .byte_valid  (byte_valid),
      .ack_done    (ack_done),
      .dec         (dec),
      .match_pulse (match_pulse),
      .match_gc    (match_gc),
      .match_rw    (match_rw),
      .ack_drive   (ack_drive)
   );

   // R7
   no_ack_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      byte_valid && byte_is_addr && !ack_enable |=> !ack_drive && !match_pulse);

   // R8
   data_no_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      byte_valid && !byte_is_addr |=> !match_pulse);

   // R3
   gc_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      match_pulse && match_gc |-> $past(gc_enable) && ($past(rx_byte) == '0));

   // R5
   rw_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      match_pulse |-> match_rw == $past(rx_byte[0]));

endmodule

// File: tb/i2c_addr_matcher_bench.sv
`timescale 1ns/1ps
module i2c_addr_matcher_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       byte_valid = 1'b0;
   logic       byte_is_addr = 1'b0;
   logic [7:0] rx_byte = 8'h00;
   logic [6:0] own_addr = 7'h00;
   logic       gc_enable = 1'b0;
   logic       ack_enable = 1'b0;
   logic [1:0] xfer_mode = 2'd0;
   logic       ack_done = 1'b0;
   logic       match_pulse, match_gc, match_rw, ack_drive;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // reference state
   bit e_pulse = 0, e_gc = 0, e_rw = 0, e_ack = 0;

   always #2.5 clk = ~clk;

   i2c_addr_matcher u_i2c_addr_matcher (
      .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_is_addr(byte_is_addr),
      .rx_byte(rx_byte), .own_addr(own_addr), .gc_enable(gc_enable),
      .ack_enable(ack_enable), .xfer_mode(xfer_mode), .ack_done(ack_done),
      .match_pulse(match_pulse), .match_gc(match_gc), .match_rw(match_rw),
      .ack_drive(ack_drive)
   );

   task automatic check(string req, logic got, bit exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %0b expected %0b at %0t", req, got, exp, $time);
      end
   endtask

   // behavioural reference, updated on each rising edge
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         e_pulse = 0; e_gc = 0; e_rw = 0; e_ack = 0;
      end else begin
         bit is_own, is_gc, matched, data_ack;
         int addr7;
         addr7   = int'(rx_byte) / 2;
         is_own  = (addr7 == int'(own_addr)) && (own_addr != 0);
         is_gc   = gc_enable && (rx_byte == 8'h00);
         matched = byte_is_addr && ack_enable && (is_own || is_gc);
         data_ack = !byte_is_addr && ack_enable && (xfer_mode >= 2'd2);
         e_pulse = byte_valid && matched;
         if (e_pulse) begin
            e_gc = is_gc;
            e_rw = rx_byte[0];
         end
         if (byte_valid) e_ack = byte_is_addr ? matched : data_ack;
         else if (ack_done) e_ack = 0;
      end
   end

   // every-cycle comparison against the reference
   always @(negedge clk) begin
      if (rst_n && !done) begin
         check("R2 pulse", match_pulse, e_pulse);
         check("R3 gc", match_gc, e_gc);
         check("R5 rw", match_rw, e_rw);
         check("R6 ack", ack_drive, e_ack);
      end
   end

   task automatic send(logic [7:0] b, bit is_addr, bit rel);
      @(negedge clk);
      rx_byte = b; byte_is_addr = is_addr; byte_valid = 1'b1; ack_done = rel;
      @(negedge clk);
      byte_valid = 1'b0; ack_done = 1'b0;
   endtask

   task automatic release_ack();
      @(negedge clk);
      ack_done = 1'b1;
      @(negedge clk);
      ack_done = 1'b0;
   endtask

   initial begin
      #200000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1", match_pulse, 0); check("R1", ack_drive, 0);
      check("R1", match_gc, 0);    check("R1", match_rw, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", match_pulse, 0); check("R1", ack_drive, 0);

      own_addr = 7'h3A; ack_enable = 1; xfer_mode = 2'd3;
      send(8'h74, 1, 0);
      check("R2", match_pulse, 1); check("R6", ack_drive, 1); check("R5", match_rw, 0);
      @(negedge clk);
      check("R2", match_pulse, 0); check("R6", ack_drive, 1);
      release_ack();
      check("R6", ack_drive, 0);

      send(8'h75, 1, 0);
      check("R5", match_rw, 1); check("R2", match_pulse, 1);
      release_ack();
      send(8'h76, 1, 0);
      check("R10", match_pulse, 0); check("R10", ack_drive, 0); check("R10", match_rw, 1);

      gc_enable = 0;
      send(8'h00, 1, 0);
      check("R3", match_pulse, 0);
      gc_enable = 1;
      send(8'h00, 1, 0);
      check("R3", match_pulse, 1); check("R3", match_gc, 1); check("R3", ack_drive, 1);
      release_ack();
      send(8'h01, 1, 0);
      check("R3", match_pulse, 0); check("R3", match_gc, 1);

      own_addr = 7'h00; gc_enable = 0;
      send(8'h00, 1, 0);
      check("R4", match_pulse, 0);
      send(8'h01, 1, 0);
      check("R4", match_pulse, 0); check("R4", ack_drive, 0);

      own_addr = 7'h3A; ack_enable = 0;
      send(8'h74, 1, 0);
      check("R7", match_pulse, 0); check("R7", ack_drive, 0);
      ack_enable = 1;
      send(8'h74, 1, 0);
      check("R7", match_pulse, 1); check("R7", ack_drive, 1);

      // R9: release and new strobe together, new decision wins
      send(8'h74, 1, 1);
      check("R9", ack_drive, 1);
      send(8'h10, 1, 1);
      check("R9", ack_drive, 0);

      xfer_mode = 2'd2;
      send(8'h55, 0, 0);
      check("R8", ack_drive, 1); check("R8", match_pulse, 0);
      xfer_mode = 2'd1;
      send(8'h74, 0, 0);
      check("R8", ack_drive, 0); check("R8", match_pulse, 0);
      xfer_mode = 2'd0;
      send(8'h55, 0, 0);
      check("R8", ack_drive, 0);
      xfer_mode = 2'd3;
      send(8'h55, 0, 0);
      check("R8", ack_drive, 1);
      ack_enable = 0;
      send(8'h55, 0, 0);
      check("R8", ack_drive, 0);

      // mixed traffic against the reference
      for (int n = 0; n < 400; n++) begin
         @(negedge clk);
         own_addr   = ($urandom % 4 == 0) ? 7'h00 : 7'h2C;
         gc_enable  = $urandom % 2;
         ack_enable = ($urandom % 4) != 0;
         xfer_mode  = 2'($urandom % 4);
         case ($urandom % 4)
            0: rx_byte = 8'h58 | 8'($urandom % 2);
            1: rx_byte = 8'($urandom % 2);
            default: rx_byte = 8'($urandom);
         endcase
         byte_is_addr = $urandom % 2;
         byte_valid   = ($urandom % 3) == 0;
         ack_done     = ($urandom % 3) == 0;
      end
      @(negedge clk);
      byte_valid = 0; ack_done = 0;
      repeat (2) @(negedge clk);

      done = 1'b1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule